// File: doc/BRIEF.md
# USB Endpoint DMA Request Controller

This block sits between two device-side endpoint byte FIFOs and a system DMA engine. Each endpoint has its own request/acknowledge pair. An endpoint set up as OUT holds bytes received from the host, and the DMA engine drains them. An endpoint set up as IN is filled by the DMA engine, and the USB core empties it toward the host. The block decides when each endpoint raises its request. It moves exactly one byte for every accepted acknowledge. It also holds one sticky run flag per endpoint, which software sets and which an end-of-transfer pulse clears.

Software reaches the block through a small register window. The window holds a control word and one byte-wide data port per endpoint. The control word carries the run flags, a test field that injects end-of-transfer, and a stored clock-select flag that is only exported. The USB core side pushes bytes into OUT FIFOs and pops bytes from IN FIFOs. A per-endpoint enable input from the core's endpoint configuration can cancel the run flag at any time.

Top module: `usb_ep_dma_link`

## Requirements
- R1: Writing the control word at offset 0x0 with bit 1 (endpoint 0) or bit 2 (endpoint 1) at 1 sets that endpoint's run flag. Writing 0 to those bits leaves the flags unchanged.
- R2: An `eot` pulse on an endpoint clears its run flag at the next clock edge. If the same cycle also writes 1 to that run bit, the clear wins.
- R3: While `dma_en[i]` is low, `dreq[i]` is low in that same cycle and the run flag is cleared at the next edge. Raising `dma_en[i]` again does not restore the flag.
- R4: `dreq[i]` is never high while the endpoint's run flag is clear.
- R5: Writing 1 to control bit 5 (endpoint 0) or bit 6 (endpoint 1) acts as an end-of-transfer for that endpoint. These bits always read back as 0.
- R6: Control bit 0 is a clock-select flag. It is written by every control write, read back, and driven on `cksel`.
- R7: For an OUT endpoint (`ep_dir_in[i]`=0) with run set, `dreq[i]` is high while the FIFO holds at least one byte. Each accepted `dack` pops one byte. `dreq` is low right after the acknowledge that empties the FIFO.
- R8: For an IN endpoint (`ep_dir_in[i]`=1) with run set, `dreq[i]` is high while the FIFO is not full. Each accepted `dack` pushes `dma_wdata`. `dreq` is low right after the acknowledge that fills the FIFO.
- R9: A read (`bus_sel`=1, `bus_wr`=0) updates `bus_rdata` one cycle later. Offset 0x0 returns the run flags in bits 2:1 and clock-select in bit 0. Offsets 0x4 and 0x8 return the endpoint 0 and endpoint 1 FIFO head in bits 7:0, with the upper bits 0. Other offsets return 0. `bus_rdata` holds its value when there is no read.
- R10: A bus write to the data port of an IN endpoint pushes bits 7:0 unless the FIFO is full or a `dack` is accepted on that endpoint in the same cycle. A bus write to the port of an OUT endpoint is ignored.
- R11: A `dack` while `dreq` is low moves no byte and sets the endpoint's `dma_err` flag. The flag stays set until reset.
- R12: Each FIFO holds 8 bytes. `core_wr` pushes into an OUT FIFO unless it is full. `core_rd` pops from an IN FIFO unless it is empty. Core strobes on the wrong direction are ignored. `fifo_head` shows the oldest byte, or 0 when the FIFO is empty.
- R13: After synchronous reset, all flags, requests, FIFOs and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ep_dir_in | input | 2 | Per endpoint: 1 = IN, 0 = OUT |
| dma_en | input | 2 | Per-endpoint DMA enable from the core |
| dreq | output | 2 | DMA request per endpoint |
| dack | input | 2 | DMA acknowledge per endpoint |
| dma_wdata | input | 8 | Byte written by the DMA engine into IN FIFOs |
| eot | input | 2 | End-of-transfer pulse per endpoint |
| core_wr | input | 2 | Core push strobe (OUT endpoints) |
| core_wdata | input | 16 | Core push bytes, endpoint i at bits 8i+7:8i |
| core_rd | input | 2 | Core pop strobe (IN endpoints) |
| fifo_head | output | 16 | Oldest byte per endpoint, endpoint i at bits 8i+7:8i |
| dma_err | output | 2 | Sticky stray-acknowledge flag |
| cksel | output | 1 | Stored clock-select flag |

## Verification
The bench drives the FIFO to exactly empty and exactly full under acknowledge. A design that looks at the old level would raise one request too many there, and the model sees it as a `dreq` mismatch. It writes zero run bits over a live run flag, fires end-of-transfer from both the pin and the test field, and drops the enable while a request is up. A design that clears on write-zero, ignores the test field or lets the request linger for a cycle gives wrong `dreq` or control readback. A long random phase mixes stray acknowledges, bus writes colliding with acknowledges, direction changes and unmapped offsets. Any slip in arbitration or in the sticky error then shows up against the queue model.

// File: rtl/usb_dma_pkg.sv
package usb_dma_pkg;
  localparam int NUM_EP     = 2;
  localparam int ADDR_W     = 4;
  localparam int REG_W      = 16;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 8;

  localparam logic [ADDR_W-1:0] CTRL_OFS  = 4'h0;
  localparam logic [ADDR_W-1:0] PORT0_OFS = 4'h4;
  localparam logic [ADDR_W-1:0] PORT1_OFS = 4'h8;

  localparam int CKSEL_BIT = 0;
  localparam int RUN_LSB   = 1;
  localparam int TEOT_LSB  = 5;

  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_CTRL  = 2'd1,
    HIT_PORT0 = 2'd2,
    HIT_PORT1 = 2'd3
  } reg_hit_e;
endpackage

// File: rtl/ep_byte_fifo.sv
module ep_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/ep_dma_chan.sv
module ep_dma_chan #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_in,
  input  logic              dma_en,
  input  logic              run_set,
  input  logic              eot_any,
  input  logic              dack,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_rd,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] port_wdata,
  output logic              run,
  output logic              dreq,
  output logic              err,
  output logic [DATA_W-1:0] head
);
  logic              run_q, err_q;
  logic              empty, full;
  logic              level_ok, accept;
  logic              f_push, f_pop;
  logic [DATA_W-1:0] f_data;

  always_ff @(posedge clk) begin
    if (rst)              run_q <= 1'b0;
    else if (!dma_en)     run_q <= 1'b0;
    else if (eot_any)     run_q <= 1'b0;
    else if (run_set)     run_q <= 1'b1;
  end

  assign level_ok = dir_in ? !full : !empty;
  assign dreq     = run_q && dma_en && level_ok;
  assign accept   = dack && dreq;

  always_ff @(posedge clk) begin
    if (rst)                  err_q <= 1'b0;
    else if (dack && !dreq)   err_q <= 1'b1;
  end

  always_comb begin
    if (dir_in) begin
      f_push = accept || port_wr;
      f_data = accept ? dma_wdata : port_wdata;
      f_pop  = core_rd;
    end else begin
      f_push = core_wr;
      f_data = core_wdata;
      f_pop  = accept;
    end
  end

  ep_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (f_push),
    .push_data (f_data),
    .pop       (f_pop),
    .head      (head),
    .empty     (empty),
    .full      (full)
  );

  assign run = run_q;
  assign err = err_q;
endmodule

// File: rtl/usb_dma_regs.sv
module usb_dma_regs
  import usb_dma_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = REG_W,
  parameter int DW = DATA_W,
  parameter int NE = NUM_EP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [RW-1:0]    bus_wdata,
  input  logic [NE-1:0]    run,
  input  logic [NE*DW-1:0] head,
  output logic [NE-1:0]    run_set,
  output logic [NE-1:0]    eot_test,
  output logic [NE-1:0]    port_wr,
  output logic [DW-1:0]    port_wdata,
  output logic             cksel,
  output logic [RW-1:0]    rdata
);
  reg_hit_e      hit;
  logic          wr_ctrl;
  logic          cksel_q;
  logic [RW-1:0] rdata_q, view;

  always_comb begin
    case (bus_addr)
      CTRL_OFS:  hit = HIT_CTRL;
      PORT0_OFS: hit = HIT_PORT0;
      PORT1_OFS: hit = HIT_PORT1;
      default:   hit = HIT_NONE;
    endcase
  end

  assign wr_ctrl    = bus_sel && bus_wr && (hit == HIT_CTRL);
  assign run_set    = wr_ctrl ? bus_wdata[RUN_LSB +: NE]  : '0;
  assign eot_test   = wr_ctrl ? bus_wdata[TEOT_LSB +: NE] : '0;
  assign port_wr[0] = bus_sel && bus_wr && (hit == HIT_PORT0);
  assign port_wr[1] = bus_sel && bus_wr && (hit == HIT_PORT1);
  assign port_wdata = bus_wdata[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst)          cksel_q <= 1'b0;
    else if (wr_ctrl) cksel_q <= bus_wdata[CKSEL_BIT];
  end

  always_comb begin
    view = '0;
    case (hit)
      HIT_CTRL: begin
        view[CKSEL_BIT]       = cksel_q;
        view[RUN_LSB +: NE]   = run;
      end
      HIT_PORT0: view[DW-1:0] = head[0 +: DW];
      HIT_PORT1: view[DW-1:0] = head[DW +: DW];
      default:   view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                    rdata_q <= '0;
    else if (bus_sel && !bus_wr) rdata_q <= view;
  end

  assign cksel = cksel_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/usb_ep_dma_link.sv
module usb_ep_dma_link
  import usb_dma_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int DEPTH = FIFO_DEPTH,
  parameter int AW    = ADDR_W,
  parameter int RW    = REG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [RW-1:0]        bus_wdata,
  output logic [RW-1:0]        bus_rdata,
  input  logic [NUM_EP-1:0]    ep_dir_in,
  input  logic [NUM_EP-1:0]    dma_en,
  output logic [NUM_EP-1:0]    dreq,
  input  logic [NUM_EP-1:0]    dack,
  input  logic [DW-1:0]        dma_wdata,
  input  logic [NUM_EP-1:0]    eot,
  input  logic [NUM_EP-1:0]    core_wr,
  input  logic [NUM_EP*DW-1:0] core_wdata,
  input  logic [NUM_EP-1:0]    core_rd,
  output logic [NUM_EP*DW-1:0] fifo_head,
  output logic [NUM_EP-1:0]    dma_err,
  output logic                 cksel
);
  logic [NUM_EP-1:0] run_q;
  logic [NUM_EP-1:0] run_set, eot_test, port_wr;
  logic [DW-1:0]     port_wdata;

  usb_dma_regs #(.AW(AW), .RW(RW), .DW(DW), .NE(NUM_EP)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .run        (run_q),
    .head       (fifo_head),
    .run_set    (run_set),
    .eot_test   (eot_test),
    .port_wr    (port_wr),
    .port_wdata (port_wdata),
    .cksel      (cksel),
    .rdata      (bus_rdata)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    ep_dma_chan #(.DATA_W(DW), .DEPTH(DEPTH)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .dir_in     (ep_dir_in[g]),
      .dma_en     (dma_en[g]),
      .run_set    (run_set[g]),
      .eot_any    (eot[g] || eot_test[g]),
      .dack       (dack[g]),
      .dma_wdata  (dma_wdata),
      .core_wr    (core_wr[g]),
      .core_wdata (core_wdata[g*DW +: DW]),
      .core_rd    (core_rd[g]),
      .port_wr    (port_wr[g]),
      .port_wdata (port_wdata),
      .run        (run_q[g]),
      .dreq       (dreq[g]),
      .err        (dma_err[g]),
      .head       (fifo_head[g*DW +: DW])
    );
  end
endmodule

// File: rtl/usb_dma_checker.sv
module usb_dma_checker
  import usb_dma_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [REG_W-1:0]     bus_wdata,
  input logic [NUM_EP-1:0]    dma_en,
  input logic [NUM_EP-1:0]    eot,
  input logic [NUM_EP-1:0]    dreq,
  input logic [NUM_EP-1:0]    dack,
  input logic [NUM_EP-1:0]    dma_err,
  input logic [NUM_EP-1:0]    run
);
  logic ctrl_wr;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == CTRL_OFS);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    assert_eot_clears_R2: assert property (@(posedge clk) disable iff (rst)
      eot[i] |=> !run[i]);

    assert_enable_low_clears_R3: assert property (@(posedge clk) disable iff (rst)
      !dma_en[i] |=> !run[i]);

    assert_req_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
      dreq[i] |-> (run[i] && dma_en[i]));

    assert_zero_write_keeps_R1: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && !bus_wdata[RUN_LSB+i] && !bus_wdata[TEOT_LSB+i] &&
       run[i] && dma_en[i] && !eot[i]) |=> run[i]);

    assert_stray_ack_flags_R11: assert property (@(posedge clk) disable iff (rst)
      (dack[i] && !dreq[i]) |=> dma_err[i]);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
      dma_err[i] |=> dma_err[i]);
  end
endmodule

bind usb_ep_dma_link usb_dma_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dma_en    (dma_en),
  .eot       (eot),
  .dreq      (dreq),
  .dack      (dack),
  .dma_err   (dma_err),
  .run       (run_q)
);

// File: tb/tb_usb_ep_dma_link.sv
`timescale 1ns/1ps
module tb_usb_ep_dma_link;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [1:0]  ep_dir_in = 0, dma_en = 0, dack = 0, eot = 0, core_wr = 0, core_rd = 0;
  logic [1:0]  dreq, dma_err;
  logic [7:0]  dma_wdata = 0;
  logic [15:0] core_wdata = 0;
  logic [15:0] fifo_head;
  logic        cksel;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0]  mq0[$];
  logic [7:0]  mq1[$];
  logic [1:0]  run_m = 0, err_m = 0;
  logic        cksel_m = 0;
  logic [15:0] rdata_m = 0;
  bit          model_on = 0;

  always #2.5 clk = ~clk;

  usb_ep_dma_link dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_dir_in(ep_dir_in), .dma_en(dma_en),
    .dreq(dreq), .dack(dack), .dma_wdata(dma_wdata), .eot(eot), .core_wr(core_wr),
    .core_wdata(core_wdata), .core_rd(core_rd), .fifo_head(fifo_head), .dma_err(dma_err),
    .cksel(cksel)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int qsize(input int i);
    return (i == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic logic [7:0] qhead(input int i);
    if (qsize(i) == 0) return 8'h00;
    return (i == 0) ? mq0[0] : mq1[0];
  endfunction

  function automatic logic exp_dreq(input int i);
    logic lvl;
    lvl = ep_dir_in[i] ? (qsize(i) != 8) : (qsize(i) != 0);
    return run_m[i] && dma_en[i] && lvl;
  endfunction

  task automatic model_step();
    logic       ctrlwr;
    logic [1:0] dq;
    ctrlwr = bus_sel && bus_wr && bus_addr == 4'h0;
    for (int i = 0; i < 2; i++) dq[i] = exp_dreq(i);
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        4'h0: rdata_m = {13'd0, run_m, cksel_m};
        4'h4: rdata_m = {8'h00, qhead(0)};
        4'h8: rdata_m = {8'h00, qhead(1)};
        default: rdata_m = 16'h0000;
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      logic acc, portwr, full, empty, dopush, dopop, eotx, setx;
      logic [7:0] pdata;
      full   = qsize(i) == 8;
      empty  = qsize(i) == 0;
      acc    = dack[i] && dq[i];
      portwr = bus_sel && bus_wr && bus_addr == ((i == 0) ? 4'h4 : 4'h8);
      if (dack[i] && !dq[i]) err_m[i] = 1'b1;
      if (!ep_dir_in[i]) begin
        dopop  = acc;
        dopush = core_wr[i] && !full;
        pdata  = core_wdata[i*8 +: 8];
      end else begin
        dopop  = core_rd[i] && !empty;
        dopush = (acc || portwr) && !full;
        pdata  = acc ? dma_wdata : bus_wdata[7:0];
      end
      if (i == 0) begin
        if (dopop) void'(mq0.pop_front());
        if (dopush) mq0.push_back(pdata);
      end else begin
        if (dopop) void'(mq1.pop_front());
        if (dopush) mq1.push_back(pdata);
      end
      eotx = eot[i] || (ctrlwr && bus_wdata[5+i]);
      setx = ctrlwr && bus_wdata[1+i];
      if (!dma_en[i])  run_m[i] = 1'b0;
      else if (eotx)   run_m[i] = 1'b0;
      else if (setx)   run_m[i] = 1'b1;
    end
    if (ctrlwr) cksel_m = bus_wdata[0];
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      chk($sformatf("R4 R7 R8 dreq ep%0d", i), {15'd0, dreq[i]}, {15'd0, exp_dreq(i)});
      chk($sformatf("R11 dma_err ep%0d", i), {15'd0, dma_err[i]}, {15'd0, err_m[i]});
    end
    chk("R12 fifo_head", fifo_head, {qhead(1), qhead(0)});
    chk("R6 cksel", {15'd0, cksel}, {15'd0, cksel_m});
    chk("R9 bus_rdata", bus_rdata, rdata_m);
  endtask

  // one clock: inputs already set at the falling edge
  task automatic cycle();
    @(posedge clk);
    if (model_on) model_step();
    #1;
    if (model_on) compare_all();
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; dack = 0; eot = 0; core_wr = 0; core_rd = 0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cycle();
  endtask

  task automatic rd_reg(input logic [3:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    cycle();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    model_on = 1;
    #1;
    // R13: reset state
    chk("R13 dreq", {14'd0, dreq}, 16'h0);
    chk("R13 dma_err", {14'd0, dma_err}, 16'h0);
    chk("R13 fifo_head", fifo_head, 16'h0);
    chk("R13 bus_rdata", bus_rdata, 16'h0);
    chk("R13 cksel", {15'd0, cksel}, 16'h0);

    // R6: clock select stored and read back
    wr_reg(4'h0, 16'h0001);
    chk("R6 cksel set", {15'd0, cksel}, 16'h1);
    rd_reg(4'h0);
    chk("R9 R6 ctrl read", bus_rdata, 16'h0001);

    // OUT endpoint 0
    dma_en = 2'b11; ep_dir_in = 2'b10;
    for (int k = 0; k < 3; k++) begin
      core_wr = 2'b01; core_wdata = {8'h00, 8'hA1 + 8'(k)};
      cycle();
    end
    chk("R4 no request without run", {15'd0, dreq[0]}, 16'h0);
    wr_reg(4'h0, 16'h0003);
    chk("R1 R7 dreq after run set", {15'd0, dreq[0]}, 16'h1);
    rd_reg(4'h4);
    chk("R9 port0 head read", bus_rdata, 16'h00A1);
    for (int k = 0; k < 3; k++) begin
      chk("R7 head before ack", {8'h00, fifo_head[7:0]}, {8'h00, 8'hA1 + 8'(k)});
      dack = 2'b01;
      cycle();
    end
    chk("R7 dreq drops on empty", {15'd0, dreq[0]}, 16'h0);
    dack = 2'b01;
    cycle();
    chk("R11 stray ack sets err", {15'd0, dma_err[0]}, 16'h1);
    wr_reg(4'h0, 16'h0001);
    rd_reg(4'h0);
    chk("R1 zero write keeps run", bus_rdata, 16'h0003);
    eot = 2'b01;
    cycle();
    rd_reg(4'h0);
    chk("R2 eot clears run", bus_rdata, 16'h0001);
    chk("R11 err stays set", {15'd0, dma_err[0]}, 16'h1);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = 16'h0077;
    cycle();
    chk("R10 write to OUT port ignored", fifo_head, 16'h0000);

    // IN endpoint 1
    wr_reg(4'h0, 16'h0005);
    chk("R8 dreq on empty IN", {15'd0, dreq[1]}, 16'h1);
    for (int k = 0; k < 8; k++) begin
      dack = 2'b10; dma_wdata = 8'h10 + 8'(k);
      cycle();
    end
    chk("R8 dreq drops on full", {15'd0, dreq[1]}, 16'h0);
    core_rd = 2'b10;
    cycle();
    chk("R12 head after core pop", {8'h00, fifo_head[15:8]}, 16'h0011);
    chk("R8 dreq back after pop", {15'd0, dreq[1]}, 16'h1);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h8; bus_wdata = 16'hFF55;
    cycle();
    chk("R10 port write fills IN", {15'd0, dreq[1]}, 16'h0);
    rd_reg(4'h0);
    chk("R9 ctrl read with run1", bus_rdata, 16'h0005);
    wr_reg(4'h0, 16'h0040);
    rd_reg(4'h0);
    chk("R5 test eot clears run1", bus_rdata, 16'h0000);

    // R3: enable drop
    core_rd = 2'b10;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 16'h0004;
    cycle();
    chk("R3 dreq up before drop", {15'd0, dreq[1]}, 16'h1);
    dma_en = 2'b01;
    #1;
    chk("R3 dreq low with enable low", {15'd0, dreq[1]}, 16'h0);
    @(negedge clk);
    cycle();
    dma_en = 2'b11;
    rd_reg(4'h0);
    chk("R3 run cleared", bus_rdata, 16'h0000);
    chk("R3 no restore", {15'd0, dreq[1]}, 16'h0);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 2) ep_dir_in = 2'($urandom);
      dma_en = ($urandom_range(0, 99) < 5) ? 2'($urandom) : 2'b11;
      dack = 2'($urandom) & 2'($urandom);
      dma_wdata = 8'($urandom);
      eot = ($urandom_range(0, 99) < 3) ? 2'($urandom) : 2'b00;
      core_wr = 2'($urandom);
      core_rd = 2'($urandom) & 2'($urandom);
      core_wdata = 16'($urandom);
      bus_sel = ($urandom_range(0, 99) < 30);
      bus_wr = 1'($urandom);
      case ($urandom_range(0, 4))
        0: bus_addr = 4'h0;
        1: bus_addr = 4'h4;
        2: bus_addr = 4'h8;
        3: bus_addr = 4'hC;
        default: bus_addr = 4'h2;
      endcase
      bus_wdata = 16'($urandom);
      if (bus_addr == 4'h0 && $urandom_range(0, 3) != 0) bus_wdata[6:5] = 2'b00;
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule